// File: doc/BRIEF.md
# Parallel Unit Condition and Decimal Correction Unit

This block is a one-stage arithmetic unit for sub-word work on a W-bit word, 32 bits by default. It performs three operations. Unit-xor is a bitwise exclusive OR. Unit add-complement adds the first operand to the bitwise complement of the second. Decimal correct builds a per-digit correction of 6 from a stored carry vector and either adds it to an operand or subtracts it.

Alongside the result, it evaluates one condition from a 4-bit field. The condition tests every byte, every halfword or every BCD digit of the word in parallel: some lane is zero, or some lane produced a carry. A true condition raises the nullify flag, which tells the pipeline to skip the next instruction. Unit add-complement can also raise a one-cycle trap pulse when its condition holds.

The unit accepts one operation on each cycle where `go` is high. Its outputs are registered and appear one clock edge later. Operand fetch and instruction decode are left to the surrounding pipeline.

Top module: `unit_cond_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operation, `res_q`, `nullify_q` and `trap_q` are all zero.
- R2: With `op` = 0 or 3 (unit-xor), the result is `opa ^ opb`. The adder inputs used for carries are x = `opa`, y = `opb`.
- R3: With `op` = 1 (add-complement), the result is `opa + ~opb` modulo 2^W. The adder inputs are x = `opa`, y = `~opb`.
- R4: With `op` = 2 (decimal correct), a correction value k is built per 4-bit digit i. The digit of k is 6 when `carry_vec[4i+3]` is 1 and `opt` = 1, or when that bit is 0 and `opt` = 0; otherwise it is 0. With `opt` = 1 the result is `opb + k`, with x = `opb` and y = k. With `opt` = 0 the result is `opb - k`, with x = `opb` and y = `~k`.
- R5: The carry vector used by the conditions is `((x | y) & ~res) | (x & y)`, where res is the new result.
- R6: `cond[3:1]` selects the test. The codes are: 0 never, 1 never, 2 some byte zero, 3 some halfword zero, 4 digit carry, 5 never, 6 byte carry, 7 halfword carry. `cond[0]` = 1 inverts the selected test.
- R7: "Some byte zero" is true when any 8-bit lane of the result is zero. "Some halfword zero" is true when any 16-bit lane of the result is zero.
- R8: "Digit carry", "byte carry" and "halfword carry" are true when any bit 4i+3, 8i+7 or 16i+15 of the carry vector is set, respectively.
- R9: When `cond` = 0, `nullify_q` becomes 0 and `trap_q` stays 0. Otherwise `nullify_q` becomes the condition value.
- R10: `trap_q` is high for exactly the one cycle after an accepted add-complement with `opt` = 1, a nonzero `cond` and a true condition. No other operation ever traps.
- R11: Outputs update one clock edge after a cycle with `go` high. On cycles where `go` is low, `res_q` and `nullify_q` hold and `trap_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Accept an operation this cycle |
| op | input | 2 | Operation: 0/3 unit-xor, 1 add-complement, 2 decimal correct |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| carry_vec | input | W | Stored per-bit carry vector |
| cond | input | 4 | Condition field |
| opt | input | 1 | Intermediate form (decimal correct) or trap enable (add-complement) |
| res_q | output | W | Registered result |
| nullify_q | output | 1 | Registered condition outcome |
| trap_q | output | 1 | One-cycle condition trap pulse |

## Verification
Several properties are checked on every cycle:
- the trap pulse always has a legal source: the previous cycle carried an accepted add-complement with `opt` set and a nonzero field;
- a trap always comes with nullify;
- a zero field, or a never code, clears nullify;
- unit-xor produces the xor of its operands;
- outputs hold while idle.

The bench sweeps every operation, condition field and option value over operand vectors chosen to put zero lanes and carries at each lane boundary. Only these sweeps can show that the lane tests and the decimal correction produce the right values.

// File: rtl/uc_pkg.sv
package uc_pkg;
    typedef enum logic [1:0] {
        UOP_XOR     = 2'd0,
        UOP_ADDCM   = 2'd1,
        UOP_DCOR    = 2'd2,
        UOP_XOR_ALT = 2'd3
    } uop_e;

    typedef enum logic [2:0] {
        SEL_NEVER   = 3'd0,
        SEL_UNDEF1  = 3'd1,
        SEL_BYTE_Z  = 3'd2,
        SEL_HALF_Z  = 3'd3,
        SEL_DIG_C   = 3'd4,
        SEL_UNDEF5  = 3'd5,
        SEL_BYTE_C  = 3'd6,
        SEL_HALF_C  = 3'd7
    } sel_e;
endpackage

// File: rtl/uc_dcor_const.sv
module uc_dcor_const #(
    parameter int W = 32
) (
    input  logic [W-1:0] carry_vec,
    input  logic         intermediate,
    output logic [W-1:0] corr
);
    localparam int NDIG = W / 4;

    // one correction nibble per digit, driven by that digit's top carry bit
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign corr[4*g+3:4*g] =
            (carry_vec[4*g+3] == intermediate) ? 4'h6 : 4'h0;
    end
endmodule

// File: rtl/uc_cond_eval.sv
module uc_cond_eval #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] res,
    input  logic [3:0]   cond,
    output logic         hit
);
    import uc_pkg::*;

    function automatic logic [W-1:0] lane_mask(int period, int pos);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = ((i % period) == pos);
        return m;
    endfunction

    localparam logic [W-1:0] BYTE_LO = lane_mask(8, 0);
    localparam logic [W-1:0] BYTE_HI = lane_mask(8, 7);
    localparam logic [W-1:0] HALF_LO = lane_mask(16, 0);
    localparam logic [W-1:0] HALF_HI = lane_mask(16, 15);
    localparam logic [W-1:0] DIG_HI  = lane_mask(4, 3);

    logic [W-1:0] cb;
    logic         byte_zero, half_zero, base;
    sel_e         sel;

    always_comb begin
        cb        = ((x | y) & ~res) | (x & y);
        byte_zero = |((res - BYTE_LO) & ~res & BYTE_HI);
        half_zero = |((res - HALF_LO) & ~res & HALF_HI);
        sel       = sel_e'(cond[3:1]);
        unique case (sel)
            SEL_BYTE_Z: base = byte_zero;
            SEL_HALF_Z: base = half_zero;
            SEL_DIG_C:  base = |(cb & DIG_HI);
            SEL_BYTE_C: base = |(cb & BYTE_HI);
            SEL_HALF_C: base = |(cb & HALF_HI);
            default:    base = 1'b0;
        endcase
        hit = base ^ cond[0];
    end
endmodule

// File: rtl/unit_cond_alu.sv
module unit_cond_alu #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] carry_vec,
    input  logic [3:0]   cond,
    input  logic         opt,
    output logic [W-1:0] res_q,
    output logic         nullify_q,
    output logic         trap_q
);
    import uc_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic         nul;
        logic         trap;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] corr, x, y, sum;
    logic         hit;
    uop_e         uop;

    uc_dcor_const #(.W(W)) u_dcor (
        .carry_vec    (carry_vec),
        .intermediate (opt),
        .corr         (corr)
    );

    uc_cond_eval #(.W(W)) u_cond (
        .x    (x),
        .y    (y),
        .res  (sum),
        .cond (cond),
        .hit  (hit)
    );

    always_comb begin
        uop = uop_e'(op);
        unique case (uop)
            UOP_ADDCM: begin
                x   = opa;
                y   = ~opb;
                sum = opa + ~opb;
            end
            UOP_DCOR: begin
                x   = opb;
                y   = opt ? corr : ~corr;
                sum = opt ? (opb + corr) : (opb - corr);
            end
            default: begin
                x   = opa;
                y   = opb;
                sum = opa ^ opb;
            end
        endcase

        st_d      = st_q;
        st_d.trap = 1'b0;
        if (go) begin
            st_d.res  = sum;
            st_d.nul  = (cond != 4'd0) && hit;
            st_d.trap = (cond != 4'd0) && hit && opt && (uop == UOP_ADDCM);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_q     = st_q.res;
    assign nullify_q = st_q.nul;
    assign trap_q    = st_q.trap;
endmodule

// File: rtl/uc_checker.sv
module uc_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         go,
    input logic [1:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [3:0]   cond,
    input logic         opt,
    input logic [W-1:0] res_q,
    input logic         nullify_q,
    input logic         trap_q
);
    p_trap_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> $past(go && op == 2'd1 && opt && cond != 4'd0));

    p_trap_nullifies_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> nullify_q);

    p_zero_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go && cond == 4'd0 |=> !nullify_q && !trap_q);

    p_never_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        go && !cond[0] && (cond[3:1] == 3'd0 || cond[3:1] == 3'd1 || cond[3:1] == 3'd5)
        |=> !nullify_q);

    p_xor_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go && (op == 2'd0 || op == 2'd3) |=> res_q == $past(opa ^ opb));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(res_q) && $stable(nullify_q) && !trap_q);
endmodule

bind unit_cond_alu uc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .cond      (cond),
    .opt       (opt),
    .res_q     (res_q),
    .nullify_q (nullify_q),
    .trap_q    (trap_q)
);

// File: tb/sim_unit_cond_alu.sv
module sim_unit_cond_alu;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go = 1'b0;
    logic [1:0]   op = '0;
    logic [W-1:0] opa = '0, opb = '0, carry_vec = '0;
    logic [3:0]   cond = '0;
    logic         opt = 1'b0;
    logic [W-1:0] res_q;
    logic         nullify_q, trap_q;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    unit_cond_alu #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .op(op), .opa(opa), .opb(opb),
        .carry_vec(carry_vec), .cond(cond), .opt(opt),
        .res_q(res_q), .nullify_q(nullify_q), .trap_q(trap_q)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference built from the requirement text
    task automatic model(input logic [1:0] o, input logic [W-1:0] a, b, cv,
                         input logic [3:0] c, input logic t,
                         output logic [W-1:0] r, output logic nul, trp);
        logic [W-1:0] x, y, k, cb;
        logic base;
        k = '0;
        for (int i = 0; i < W/4; i++)
            if ((cv[4*i+3] && t) || (!cv[4*i+3] && !t)) k[4*i +: 4] = 4'd6;
        case (o)
            2'd1: begin x = a; y = ~b; r = a + ~b; end
            2'd2: begin
                x = b;
                if (t) begin y = k;  r = b + k; end
                else   begin y = ~k; r = b - k; end
            end
            default: begin x = a; y = b; r = a ^ b; end
        endcase
        cb = ((x | y) & ~r) | (x & y);
        base = 1'b0;
        case (c[3:1])
            3'd2: for (int i = 0; i < W/8; i++)  if (r[8*i +: 8] == 8'd0) base = 1'b1;
            3'd3: for (int i = 0; i < W/16; i++) if (r[16*i +: 16] == 16'd0) base = 1'b1;
            3'd4: for (int i = 0; i < W/4; i++)  if (cb[4*i+3]) base = 1'b1;
            3'd6: for (int i = 0; i < W/8; i++)  if (cb[8*i+7]) base = 1'b1;
            3'd7: for (int i = 0; i < W/16; i++) if (cb[16*i+15]) base = 1'b1;
            default: base = 1'b0;
        endcase
        if (c[0]) base = !base;
        nul = (c != 4'd0) && base;
        trp = nul && (o == 2'd1) && t;
    endtask

    logic [W-1:0] va [8] = '{32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0100_FF00,
                             32'h8000_0001, 32'h9999_9999, 32'h00FF_00FF, 32'h7F80_0880};
    logic [W-1:0] vb [8] = '{32'h0000_0000, 32'h1234_5678, 32'h0000_0001, 32'hFF00_00FF,
                             32'h7FFF_FFFF, 32'h0666_6666, 32'hFFFF_0000, 32'h0880_7F80};
    logic [W-1:0] vc [8] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8888_8888, 32'h0808_0808,
                             32'h8000_0008, 32'h1234_5678, 32'hF0F0_F0F0, 32'h8008_8008};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] er;
        logic en, et;
        repeat (3) @(negedge clk);
        check("R1 res", res_q, '0);
        check("R1 nullify", W'(nullify_q), '0);
        check("R1 trap", W'(trap_q), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 res after release", res_q, '0);

        // R2 R3 R4 R5 R6 R7 R8 R9 R10: full sweep
        for (int v = 0; v < 8; v++)
            for (int o = 0; o < 4; o++)
                for (int c = 0; c < 16; c++)
                    for (int t = 0; t < 2; t++) begin
                        go = 1'b1; op = 2'(o); opa = va[v]; opb = vb[v];
                        carry_vec = vc[v]; cond = 4'(c); opt = t[0];
                        model(op, opa, opb, carry_vec, cond, opt, er, en, et);
                        @(negedge clk);
                        go = 1'b0;
                        check("R2/R3/R4 result", res_q, er);
                        check("R5/R6/R7/R8/R9 nullify", W'(nullify_q), W'(en));
                        check("R10 trap", W'(trap_q), W'(et));
                    end

        // R11 hold and R10 single-cycle pulse: trapping op, then idle
        go = 1'b1; op = 2'd1; opa = 32'h0000_0005; opb = 32'h0000_0004;
        cond = 4'd1; opt = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R10 trap raised", W'(trap_q), W'(1));
        check("R3 result 5+~4", res_q, 32'h0000_0000);
        opa = 32'hDEAD_BEEF; opb = 32'h1; cond = 4'd0;
        @(negedge clk);
        check("R10 trap drops after one cycle", W'(trap_q), W'(0));
        check("R11 result held", res_q, 32'h0000_0000);
        check("R11 nullify held", W'(nullify_q), W'(1));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule